// File: doc/BRIEF.md
# Fractional Prescaler Baud Generator

This block turns the system clock into bit-rate clock enables for a serial transmitter and a serial receiver. The internal path has two stages in series. A prescaler divides by a programmable factor from 1 to 16 in half steps. An 11-bit down-counter then divides the prescaler ticks by a further whole number. The transmitter and the receiver each choose, on their own select input, between this internal chain and an external clock pin. The external pin is synchronized to the system clock and reduced to one enable per rising edge.

Software configures the block through two 8-bit registers that it can read back. The divisor-low register holds bits 7:0 of the 11-bit divisor. The prescale register holds the 5-bit prescale code in bits 7:3 and divisor bits 10:8 in bits 2:0. A write to either register restarts both divider stages, so a new setting takes effect from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, both configuration registers read 0 and neither enable output pulses while its internal source is selected.
- R2: Prescale code c (prescale register bits 7:3) from 1 to 31 divides the system clock by (c+1)/2 on average. Code 0 stops the internal chain, and no internal enable is produced.
- R3: When (c+1)/2 is not a whole number, the prescaler periods alternate between floor and ceiling lengths. After a restart the floor period comes first, so the k-th tick falls k*floor + k/2 (integer division) cycles after the restart.
- R4: The divisor N is {prescale register bits 2:0, divisor-low register bits 7:0}. The internal enable is a one-cycle pulse on every (N+1)-th prescaler tick. After a restart the first pulse falls on tick N+1.
- R5: A write to either register restarts both stages. The cycle that follows the write edge counts as cycle 1 of the new sequence, and a write that leaves the values unchanged still restarts the phase.
- R6: A rising edge on the external clock pin gives exactly one enable cycle. That cycle is the second cycle after the edge is set up ahead of a clock edge. A pin held high gives no further pulses.
- R7: tx_src_ext and rx_src_ext each pick the external pulse (1) or the internal enable (0) for their own output, independently of each other.
- R8: cfg_rdata returns the divisor-low register when cfg_sel is 0 and the prescale register when cfg_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 divisor-low, 1 prescale |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| ext_clk_pin | input | 1 | Asynchronous external bit clock |
| tx_src_ext | input | 1 | Transmitter source: 1 external pin, 0 internal chain |
| rx_src_ext | input | 1 | Receiver source: 1 external pin, 0 internal chain |
| tx_baud_en | output | 1 | Transmitter bit-rate enable |
| rx_baud_en | output | 1 | Receiver bit-rate enable |

## Verification
A wrong prescaler count or a phase that does not alternate moves the first internal enable away from its computed cycle. Because every enable comes after N+1 ticks, the error is multiplied and shows within one baud period of the restart. A wrong divisor reload or a bad split of the divisor bits shows as a wrong gap between the first and second enables. A fault in the synchronizer shows at once as a pulse that comes early, comes late or repeats, within three cycles of the pin edge.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int REG_W    = 8;
  localparam int PRE_W    = 5;
  localparam int DIV_W    = 11;
  localparam int DIV_HI_W = DIV_W - REG_W;

  typedef struct packed {
    logic [PRE_W-1:0] code;
    logic [DIV_W-1:0] div;
  } fbg_cfg_t;
endpackage

// File: rtl/fbg_cfg_regs.sv
module fbg_cfg_regs
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output fbg_cfg_t         cfg_q,
  output fbg_cfg_t         cfg_d,
  output logic             restart
);
  logic [REG_W-1:0] lo_q, lo_d, ps_q, ps_d;

  always_comb begin
    lo_d = lo_q;
    ps_d = ps_q;
    if (wr) begin
      if (sel) ps_d = wdata;
      else     lo_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      ps_q <= '0;
    end else if (wr) begin
      lo_q <= lo_d;
      ps_q <= ps_d;
    end
  end

  always_comb begin
    cfg_q.code = ps_q[REG_W-1 -: PRE_W];
    cfg_q.div  = {ps_q[DIV_HI_W-1:0], lo_q};
    cfg_d.code = ps_d[REG_W-1 -: PRE_W];
    cfg_d.div  = {ps_d[DIV_HI_W-1:0], lo_d};
    rdata      = sel ? ps_q : lo_q;
    restart    = wr;
  end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] code_q,
  input  logic [PRE_W-1:0] code_d,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W:0]   sum_q, sum_d, flo_q, flo_d;
  logic             odd_q;
  logic [PRE_W-1:0] cnt_q, cnt_n;
  logic             ph_q, ph_n;
  logic [PRE_W:0]   reload_w;

  always_comb begin
    sum_q    = {1'b0, code_q} + 1'b1;
    sum_d    = {1'b0, code_d} + 1'b1;
    flo_q    = sum_q >> 1;
    flo_d    = sum_d >> 1;
    odd_q    = sum_q[0];
    tick     = (code_q != '0) && (cnt_q == '0);
    reload_w = flo_q + {{PRE_W{1'b0}}, (odd_q & ~ph_q)} - 1'b1;
    cnt_n    = cnt_q;
    ph_n     = ph_q;
    if (restart) begin
      cnt_n = PRE_W'(flo_d - 1'b1);
      ph_n  = 1'b0;
    end else if (tick) begin
      cnt_n = reload_w[PRE_W-1:0];
      ph_n  = ~ph_q;
    end else if (code_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
    end
  end

  AST_PRE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0) |-> ({1'b0, cnt_q} < flo_q + {{PRE_W{1'b0}}, odd_q})); // R3
  AST_PRE_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (flo_q > 1 && tick && !restart) |=> !tick); // R2
endmodule

// File: rtl/fbg_divisor.sv
module fbg_divisor
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  input  logic             restart,
  input  logic             tick,
  output logic             baud_en
);
  logic [DIV_W-1:0] dcnt_q, dcnt_n;

  always_comb begin
    baud_en = tick && (dcnt_q == '0);
    dcnt_n  = dcnt_q;
    if (restart)      dcnt_n = div_d;
    else if (baud_en) dcnt_n = div_q;
    else if (tick)    dcnt_n = dcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_n;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= div_q); // R4
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(dcnt_q)); // R4
endmodule

// File: rtl/fbg_ext_sync.sv
module fbg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_n;
  logic              prev_q;

  always_comb begin
    sync_n[0] = pin;
    for (int i = 1; i < STAGES; i++) sync_n[i] = sync_q[i-1];
    rise = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[STAGES-1];
    end
  end

  AST_EXT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             ext_clk_pin,
  input  logic             tx_src_ext,
  input  logic             rx_src_ext,
  output logic             tx_baud_en,
  output logic             rx_baud_en
);
  logic     rst_meta_q, rst_sync_q;
  fbg_cfg_t cfg_q, cfg_d;
  logic     restart, pre_tick, int_en, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fbg_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr      (cfg_wr),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .cfg_q   (cfg_q),
    .cfg_d   (cfg_d),
    .restart (restart)
  );

  fbg_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .code_q  (cfg_q.code),
    .code_d  (cfg_d.code),
    .restart (restart),
    .tick    (pre_tick)
  );

  fbg_divisor u_div (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .div_q   (cfg_q.div),
    .div_d   (cfg_d.div),
    .restart (restart),
    .tick    (pre_tick),
    .baud_en (int_en)
  );

  fbg_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .pin   (ext_clk_pin),
    .rise  (ext_rise)
  );

  always_comb begin
    tx_baud_en = tx_src_ext ? ext_rise : int_en;
    rx_baud_en = rx_src_ext ? ext_rise : int_en;
  end

  AST_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cfg_q.code == '0 && !tx_src_ext) |-> !tx_baud_en); // R2
endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       ext_clk_pin = 1'b0;
  logic       tx_src_ext = 1'b0;
  logic       rx_src_ext = 1'b0;
  logic       tx_baud_en, rx_baud_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_clk_pin(ext_clk_pin),
    .tx_src_ext(tx_src_ext), .rx_src_ext(rx_src_ext),
    .tx_baud_en(tx_baud_en), .rx_baud_en(rx_baud_en)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int tk(input int c, input int k);
    int flo = (c + 1) / 2;
    int odd = (c + 1) % 2;
    return k * flo + (odd != 0 ? k / 2 : 0);
  endfunction

  task automatic cfg_write(input logic s, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Called right after a restart; cycle 1 is the current negedge.
  task automatic measure(input int c, input int n, input string tag);
    int e1 = 0, e2 = 0, cnt = 0, mism = 0;
    int x1 = tk(c, n + 1);
    int x2 = tk(c, 2 * (n + 1));
    for (int idx = 1; idx <= x2 + 3; idx++) begin
      if (tx_baud_en !== rx_baud_en) mism++;
      if (tx_baud_en === 1'b1) begin
        cnt++;
        if (cnt == 1) e1 = idx;
        if (cnt == 2) e2 = idx;
      end
      @(negedge clk);
    end
    check({tag, " R2 R4 first enable"}, e1, x1);
    check({tag, " R3 R4 second enable"}, e2, x2);
    check({tag, " R7 tx/rx agree"}, mism, 0);
  endtask

  task automatic setup(input int c, input int n);
    logic [10:0] nv = 11'(n);
    cfg_write(1'b0, nv[7:0]);
    cfg_write(1'b1, {5'(c), nv[10:8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int pulses;
    int nlist[4] = '{0, 1, 3, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cfg_sel = 1'b0; #1; check("R1 divisor-low reset", cfg_rdata, 0);
    cfg_sel = 1'b1; #1; check("R1 prescale reset", cfg_rdata, 0);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_baud_en || rx_baud_en) pulses++;
    end
    check("R1 no enable after reset", pulses, 0);

    // R8: readback
    cfg_write(1'b0, 8'hA5);
    cfg_write(1'b1, 8'h3C);
    cfg_sel = 1'b0; #1; check("R8 read divisor-low", cfg_rdata, 'hA5);
    cfg_sel = 1'b1; #1; check("R8 read prescale", cfg_rdata, 'h3C);

    // R2 R3 R4: sweep of every prescale code with small divisors
    for (int c = 1; c < 32; c++)
      for (int j = 0; j < 4; j++) begin
        setup(c, nlist[j]);
        measure(c, nlist[j], $sformatf("c=%0d n=%0d", c, nlist[j]));
      end

    // R4: divisor bits across both registers
    setup(3, 'h1A5);  measure(3, 'h1A5, "split n=0x1A5");
    setup(1, 'h500);  measure(1, 'h500, "high n=0x500");
    setup(1, 2047);   measure(1, 2047, "max n=2047");

    // R5: rewrite of an unchanged value restarts phase
    setup(6, 4);
    repeat (13) @(negedge clk);
    cfg_write(1'b0, 8'd4);
    measure(6, 4, "R5 restart via divisor-low");
    setup(9, 2);
    repeat (7) @(negedge clk);
    cfg_write(1'b1, {5'd9, 3'd0});
    measure(9, 2, "R5 restart via prescale");

    // R2: code 0 stops the chain
    setup(0, 0);
    pulses = 0;
    for (int i = 0; i < 100; i++) begin
      if (tx_baud_en || rx_baud_en) pulses++;
      @(negedge clk);
    end
    check("R2 code 0 silent", pulses, 0);

    // R6 R7: tx external, rx internal (stopped)
    tx_src_ext = 1'b1; rx_src_ext = 1'b0;
    @(negedge clk); ext_clk_pin = 1'b1;
    @(negedge clk); check("R6 ext cycle1 low", tx_baud_en, 0);
    @(negedge clk); check("R6 ext cycle2 pulse", tx_baud_en, 1);
    check("R7 rx stays internal", rx_baud_en, 0);
    @(negedge clk); check("R6 ext cycle3 low", tx_baud_en, 0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_baud_en) pulses++;
    end
    check("R6 held pin no repeat", pulses, 0);
    ext_clk_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R7: rx external, tx internal every cycle
    setup(1, 0);
    tx_src_ext = 1'b0; rx_src_ext = 1'b1;
    ext_clk_pin = 1'b1;
    pulses = 0;
    for (int idx = 1; idx <= 6; idx++) begin
      @(negedge clk);
      if (tx_baud_en !== 1'b1) pulses++;
      if (idx == 2) check("R7 rx external pulse", rx_baud_en, 1);
      if (idx == 4) check("R7 rx single pulse", rx_baud_en, 0);
    end
    check("R7 tx internal unaffected", pulses, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule